// File: doc/BRIEF.md
# Programmable bus and engineering clock divider

This block holds one clock-control register and produces two clock-enable strobes from the system clock. The engineering strobe follows a 6-bit factor N. It pulses once every 2·N system cycles. When N is zero the strobe is held high, which passes the system clock straight through. The bus strobe runs at one half or one quarter of the system rate. A tap bit moves each bus pulse one cycle earlier inside its period, so the bus clock leads its unadvanced position.

The bus ratio uses a sparse 2-bit code, and two of its four values are not valid. A write that carries an invalid code leaves the current ratio in place. The bus ratio and the tap may not change during an external bus transfer. A write made while `bus_busy` is high is therefore parked in a pending slot and applied at the first clock edge at which `bus_busy` is low. A small state machine does this parking:
- In `ST_IDLE`, a write with the bus free is applied at once. This is the transition IDLE→IDLE.
- In `ST_IDLE`, a write with the bus busy moves the machine to `ST_HOLD`. This is the transition IDLE→HOLD.
- In `ST_HOLD`, further writes while busy merge into the pending slot. This is the transition HOLD→HOLD.
- In `ST_HOLD`, the first edge at which the bus is free applies the pending values. A write in that same cycle is merged with them. The machine returns to `ST_IDLE`. This is the transition HOLD→IDLE.

Top module: `dual_clk_divider`

## Requirements

Register layout:
- Bits [5:0] hold the engineering factor N.
- Bits [9:8] hold the bus code. Code 01 selects divide-by-2. Code 11 selects divide-by-4.
- Bit 12 holds the tap.
- All other bits are reserved.

Counter behaviour:
- Each divider keeps a phase counter.
- A counter restarts at 0 on the clock edge that updates its divider's settings.
- The counter then advances by one per cycle.
- An engineering period runs over counts 0..2N−1.
- A bus period runs over counts 0..L, where L is 1 for divide-by-2 and 3 for divide-by-4.

Requirements:
- R1: Out of reset, `rd_data` reads 0x0000_0100: N = 0, bus code 01, tap clear.
- R2: While N = 0, `eng_tick` is high on every cycle.
- R3: While N ≥ 1, `eng_tick` is high only in the cycle where the engineering count equals 2N−1. The pulses are therefore 2N cycles apart. N = 1 gives the maximum rate of one pulse every 2 cycles. Every register write restarts the engineering count.
- R4: With the tap clear, `bus_tick` is high when the bus count equals L. This gives one pulse every 2 cycles for code 01 and one pulse every 4 cycles for code 11.
- R5: A write whose bus code is 00 or 10 leaves the bus ratio unchanged. The tap and N from that same write are still taken.
- R6: With the tap set, `bus_tick` is high when the bus count equals L−1. That is one cycle earlier in each period than with the tap clear.
- R7: A write made while `bus_busy` is high does not change the bus code or the tap. Those values are applied at the first edge at which `bus_busy` is low. If several writes arrive while busy, the latest one wins. A valid code is kept if later writes carry an invalid code.
- R8: Reserved bits always read 0, and writing 1s to them has no effect.
- R9: The engineering factor N is taken at the edge of the write, even while `bus_busy` is high.
- R10: Every applied bus update, whether immediate or pending, restarts the bus count at 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| bus_busy | input | 1 | High while an external bus access is active or pending |
| rd_data | output | 32 | Current register contents |
| eng_tick | output | 1 | Engineering clock enable |
| bus_tick | output | 1 | External bus clock enable |

## Verification

The assertions check several rules on every cycle:
- Reserved read bits stay zero.
- The bus code never reads back as an invalid value.
- The bus fields do not move during a cycle that follows `bus_busy` being high.
- Bypass keeps `eng_tick` high.
- A non-bypass engineering strobe never fires twice in a row.
- A pending update always leaves `ST_HOLD` once the bus is free.

Some behaviours can only be shown by the bench's reference model over whole scenarios:
- The exact pulse position within each period, with and without the tap.
- The restart points after each write.
- The merge of several parked writes, including invalid codes.
- The wide 126-cycle period at N = 63.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    localparam int REG_W    = 32;
    localparam int ENG_W    = 6;
    localparam int ENG_LSB  = 0;
    localparam int CODE_LSB = 8;
    localparam int TAP_BIT  = 12;
    localparam int BUS_CW   = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } upd_state_t;
endpackage

// File: rtl/dcd_regs.sv
module dcd_regs
    import dcd_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int EW = ENG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    input  logic          bus_busy,
    output logic [EW-1:0] eng_div,
    output logic          bus_sel4,
    output logic          bus_tap,
    output logic          eng_restart,
    output logic          bus_restart,
    output logic          pending,
    output logic [RW-1:0] rd_data
);
    upd_state_t    state_q, state_n;
    logic [EW-1:0] eng_q, eng_n;
    logic          sel4_q, sel4_n, tap_q, tap_n;
    logic          pok_q, pok_n, psel4_q, psel4_n, ptap_q, ptap_n;
    logic          apply;

    logic [EW-1:0] w_eng;
    logic [1:0]    w_code;
    logic          w_ok, w_sel4, w_tap;

    assign w_eng  = wr_data[ENG_LSB +: EW];
    assign w_code = wr_data[CODE_LSB +: 2];
    assign w_ok   = w_code[0];
    assign w_sel4 = w_code[1];
    assign w_tap  = wr_data[TAP_BIT];

    // State and field registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            eng_q   <= '0;
            sel4_q  <= 1'b0;
            tap_q   <= 1'b0;
            pok_q   <= 1'b0;
            psel4_q <= 1'b0;
            ptap_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            eng_q   <= eng_n;
            sel4_q  <= sel4_n;
            tap_q   <= tap_n;
            pok_q   <= pok_n;
            psel4_q <= psel4_n;
            ptap_q  <= ptap_n;
        end
    end

    // Next state and update decisions
    always_comb begin
        state_n = state_q;
        eng_n   = eng_q;
        sel4_n  = sel4_q;
        tap_n   = tap_q;
        pok_n   = pok_q;
        psel4_n = psel4_q;
        ptap_n  = ptap_q;
        apply   = 1'b0;
        if (wr_en) eng_n = w_eng;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && bus_busy) begin
                    state_n = ST_HOLD;
                    pok_n   = w_ok;
                    psel4_n = w_sel4;
                    ptap_n  = w_tap;
                end else if (wr_en) begin
                    apply = 1'b1;
                    tap_n = w_tap;
                    if (w_ok) sel4_n = w_sel4;
                end
            end
            ST_HOLD: begin
                if (wr_en && bus_busy) begin
                    ptap_n = w_tap;
                    if (w_ok) begin
                        pok_n   = 1'b1;
                        psel4_n = w_sel4;
                    end
                end else if (wr_en) begin
                    apply   = 1'b1;
                    state_n = ST_IDLE;
                    tap_n   = w_tap;
                    if (w_ok)       sel4_n = w_sel4;
                    else if (pok_q) sel4_n = psel4_q;
                end else if (!bus_busy) begin
                    apply   = 1'b1;
                    state_n = ST_IDLE;
                    tap_n   = ptap_q;
                    if (pok_q) sel4_n = psel4_q;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign eng_div     = eng_q;
    assign bus_sel4    = sel4_q;
    assign bus_tap     = tap_q;
    assign eng_restart = wr_en;
    assign bus_restart = apply;
    assign pending     = (state_q == ST_HOLD);

    always_comb begin
        rd_data                     = '0;
        rd_data[ENG_LSB +: EW]      = eng_q;
        rd_data[CODE_LSB +: 2]      = {sel4_q, 1'b1};
        rd_data[TAP_BIT]            = tap_q;
    end
endmodule

// File: rtl/dcd_eng_div.sv
module dcd_eng_div #(
    parameter int EW = dcd_pkg::ENG_W,
    localparam int CW = EW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [EW-1:0] div,
    output logic          tick
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          bypass;

    assign bypass = (div == '0);
    assign last   = {div, 1'b0} - CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart)        cnt_q <= '0;
        else if (bypass)         cnt_q <= '0;
        else if (cnt_q == last)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + CW'(1);
    end

    assign tick = bypass || (cnt_q == last);
endmodule

// File: rtl/dcd_bus_div.sv
module dcd_bus_div #(
    parameter int CW = dcd_pkg::BUS_CW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel4,
    input  logic tap,
    output logic tick
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic [CW-1:0] hit;

    assign last = sel4 ? CW'(3) : CW'(1);
    assign hit  = tap ? (last - CW'(1)) : last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (restart)       cnt_q <= '0;
        else if (cnt_q == last) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
    end

    assign tick = (cnt_q == hit);
endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider
    import dcd_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int EW = ENG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    input  logic          bus_busy,
    output logic [RW-1:0] rd_data,
    output logic          eng_tick,
    output logic          bus_tick
);
    logic [EW-1:0] eng_div;
    logic          bus_sel4, bus_tap, eng_restart, bus_restart, pending;

    dcd_regs #(.RW(RW), .EW(EW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_busy(bus_busy), .eng_div(eng_div), .bus_sel4(bus_sel4),
        .bus_tap(bus_tap), .eng_restart(eng_restart),
        .bus_restart(bus_restart), .pending(pending), .rd_data(rd_data)
    );

    dcd_eng_div #(.EW(EW)) u_eng (
        .clk(clk), .rst_n(rst_n), .restart(eng_restart),
        .div(eng_div), .tick(eng_tick)
    );

    dcd_bus_div #(.CW(BUS_CW)) u_bus (
        .clk(clk), .rst_n(rst_n), .restart(bus_restart),
        .sel4(bus_sel4), .tap(bus_tap), .tick(bus_tick)
    );
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
    import dcd_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int EW = ENG_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          bus_busy,
    input logic [RW-1:0] rd_data,
    input logic          eng_tick,
    input logic          pending
);
    logic [RW-1:0] rsv_mask;
    always_comb begin
        rsv_mask                 = '1;
        rsv_mask[ENG_LSB +: EW]  = '0;
        rsv_mask[CODE_LSB +: 2]  = '0;
        rsv_mask[TAP_BIT]        = 1'b0;
    end

    // R8: reserved bits read zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & rsv_mask) == '0);

    // R5: the bus code never holds an invalid value
    a_r5_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[CODE_LSB] == 1'b1);

    // R7: bus fields frozen after a busy cycle
    a_r7_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> $stable({rd_data[CODE_LSB +: 2], rd_data[TAP_BIT]}));

    // R7: a parked update leaves HOLD once the bus is free
    a_r7_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !bus_busy) |=> !pending);

    // R2: bypass keeps the engineering enable high
    a_r2_bypass_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[ENG_LSB +: EW] == '0) |-> eng_tick);

    // R3: a divided engineering enable never fires on two cycles in a row
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tick && rd_data[ENG_LSB +: EW] != '0 && !wr_en) |=> !eng_tick);
endmodule

bind dual_clk_divider dcd_checker #(.RW(RW), .EW(EW)) u_dcd_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_busy(bus_busy),
    .rd_data(rd_data), .eng_tick(eng_tick), .pending(pending)
);

// File: tb/dual_clk_divider_bench.sv
`timescale 1ns/1ps
module dual_clk_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        bus_busy = 1'b0;
    logic [31:0] rd_data;
    logic        eng_tick, bus_tick;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference state
    int m_eng, m_sel4, m_tap, m_hold, m_pok, m_psel4, m_ptap, m_ecnt, m_bcnt;

    dual_clk_divider u_dual_clk_divider (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_busy(bus_busy), .rd_data(rd_data),
        .eng_tick(eng_tick), .bus_tick(bus_tick)
    );

    always #2 clk = ~clk;

    task automatic model_reset();
        m_eng = 0; m_sel4 = 0; m_tap = 0; m_hold = 0;
        m_pok = 0; m_psel4 = 0; m_ptap = 0; m_ecnt = 0; m_bcnt = 0;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else begin
            int w_eng, w_code, w_ok, w_sel4, w_tap, blast, app;
            w_eng  = int'(wr_data[5:0]);
            w_code = int'(wr_data[9:8]);
            w_ok   = (w_code == 1 || w_code == 3) ? 1 : 0;
            w_sel4 = (w_code == 3) ? 1 : 0;
            w_tap  = int'(wr_data[12]);
            blast  = m_sel4 ? 3 : 1;
            if (wr_en || m_eng == 0 || m_ecnt == 2*m_eng-1) m_ecnt = 0;
            else m_ecnt++;
            app = 0;
            if (wr_en && bus_busy) begin
                if (!m_hold) m_pok = 0;
                m_hold = 1;
                m_ptap = w_tap;
                if (w_ok) begin m_pok = 1; m_psel4 = w_sel4; end
            end else if (wr_en) begin
                app = 1;
                if (w_ok) m_sel4 = w_sel4;
                else if (m_hold && m_pok) m_sel4 = m_psel4;
                m_tap = w_tap;
                m_hold = 0;
            end else if (m_hold && !bus_busy) begin
                app = 1;
                if (m_pok) m_sel4 = m_psel4;
                m_tap = m_ptap;
                m_hold = 0;
            end
            if (wr_en) m_eng = w_eng;
            if (app || m_bcnt == blast) m_bcnt = 0;
            else m_bcnt++;
        end
    end

    function automatic int exp_rd();
        return m_eng | ((m_sel4 * 2 + 1) << 8) | (m_tap << 12);
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_exp, b_exp, blast;
            blast = m_sel4 ? 3 : 1;
            e_exp = (m_eng == 0 || m_ecnt == 2*m_eng-1) ? 1 : 0;
            b_exp = (m_bcnt == (m_tap ? blast-1 : blast)) ? 1 : 0;
            n_vec++;
            if (rd_data !== 32'(exp_rd())) begin
                n_bad++;
                $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, exp_rd());
            end
            if (eng_tick !== 1'(e_exp)) begin
                n_bad++;
                $display("FAIL %s eng_tick actual=%b expected=%0d", cur_req, eng_tick, e_exp);
            end
            if (bus_tick !== 1'(b_exp)) begin
                n_bad++;
                $display("FAIL %s bus_tick actual=%b expected=%0d", cur_req, bus_tick, b_exp);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        @(negedge clk); #0.5;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #0.5;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL %s watchdog actual=%0d expected<=20000", cur_req, cycles);
            finish_run();
        end
    end

    initial begin
        idle(3);
        #0.5 rst_n = 1'b1;
        cur_req = "R1"; idle(2);
        cur_req = "R2"; idle(6);
        cur_req = "R4"; idle(6);
        cur_req = "R3"; wr(32'h0000_0103); idle(20);
        cur_req = "R3"; wr(32'h0000_0101); idle(10);
        cur_req = "R4"; wr(32'h0000_0303); idle(20);
        cur_req = "R6"; wr(32'h0000_1302); idle(20);
        cur_req = "R6"; wr(32'h0000_1100); idle(10);
        cur_req = "R5"; wr(32'h0000_0005); idle(12);
        cur_req = "R5"; wr(32'h0000_1201); idle(12);
        cur_req = "R7"; bus_busy = 1'b1; wr(32'h0000_0302); idle(8);
        cur_req = "R7"; wr(32'h0000_1200); idle(4);
        #0.5 bus_busy = 1'b0; idle(12);
        cur_req = "R9"; bus_busy = 1'b1; wr(32'h0000_0104); idle(6);
        cur_req = "R10"; wr(32'h0000_1304); idle(3);
        wr(32'h0000_0004); idle(2);
        cur_req = "R10"; wr(32'h0000_1004); idle(1);
        #0.5 bus_busy = 1'b0; idle(12);
        cur_req = "R10"; bus_busy = 1'b1; wr(32'h0000_1104);
        #0.5 bus_busy = 1'b0; wr(32'h0000_0204); idle(12);
        cur_req = "R8"; wr(32'hFFFF_FFFF); idle(300);
        cur_req = "R2"; wr(32'hFFFF_E0C0); idle(10);
        finish_run();
    end
endmodule